// File: doc/BRIEF.md
# Multiplexed Interrupt Priority Vector Encoder

This block gathers twenty event interrupt sources into per-source pending flags. Each source carries a fixed 5-bit code, and a higher code means a higher priority. A per-source enable mask decides which pending flags count. The block encodes the highest enabled pending source into an 8-bit vector that software reads. Enabled pending sources also raise one registered summary interrupt request.

A read strobe on the vector clears the pending flag of the source whose code the vector shows. The vector then moves on to the next enabled source. An interrupt handler can therefore read the vector repeatedly until it returns 00H, and each code it gets back selects the service routine to run. Software can also clear pending flags through two pending registers, one 16 bits wide and one 8 bits wide. Writing a 0 to a bit clears that flag.

Top module: `irq_vector_enc`

## Requirements
- R1: A high `src_set[i]` makes the source with code i+1 pending at the next clock edge, whatever its mask bit holds.
- R2: `vec` shows the code (index+1) of the highest-coded source that is both pending and enabled, and reads 00H when no such source exists.
- R3: After reset, `vec`, `pend_lo`, `pend_hi`, `mask_rd` and `irq` are all zero. `vec[7:5]` is always zero.
- R4: A cycle with `vec_rd` high returns the `vec` shown in that cycle. The same cycle clears the pending flag of that code. After the edge, `vec` shows the next-highest enabled pending source.
- R5: If a set pulse and a clear (read-clear or write-clear) hit the same source in the same cycle, the set wins and the source stays pending.
- R6: `pend_lo` bit k reflects code k+5, so bit 0 is code 05H and bit 15 is code 14H. `pend_hi` bits 0 to 3 reflect codes 04H, 03H, 02H and 01H in that order. `pend_hi[7:4]` always read 0.
- R7: A pending-register write clears each flag whose data bit is 0. A data bit of 1 leaves the flag unchanged, and the reserved data bits of `pend_hi` have no effect.
- R8: `mask_wr` loads `mask_wdata`, and `mask_rd` returns the loaded value. Mask bit i enables code i+1. A pending source with a clear mask bit never appears in `vec` and never raises `irq`.
- R9: `irq` equals, one cycle later, the OR of all pending-and-enabled flags.
- R10: A cycle with `irq_ack` high drives `irq` low in the following cycle, even when sources stay pending. `irq` comes back the cycle after that if any enabled source is still pending.
- R11: A `vec_rd` while `vec` is 00H changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 20 | Per-source set pulses; bit i is code i+1 |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 20 | Mask write data; bit i enables code i+1 |
| mask_rd | output | 20 | Current mask register |
| pend_lo_wr | input | 1 | Low pending register write strobe |
| pend_lo_wdata | input | 16 | Write data; a 0 clears the flag |
| pend_lo | output | 16 | Pending flags for codes 05H to 14H |
| pend_hi_wr | input | 1 | High pending register write strobe |
| pend_hi_wdata | input | 8 | Write data; a 0 in bits 3:0 clears the flag |
| pend_hi | output | 8 | Pending flags for codes 04H down to 01H |
| vec_rd | input | 1 | Vector read strobe (clear-on-read) |
| vec | output | 8 | Priority vector |
| irq_ack | input | 1 | Summary interrupt acknowledge |
| irq | output | 1 | Summary interrupt request |

## Verification
The checkers assume the following about the inputs:
- Each bus access (`vec_rd`, `mask_wr`, a pending-register write) is a single-cycle strobe, with its data stable in that cycle.
- Set pulses may arrive in any cycle, including together with clears.
- `irq_ack` is an isolated pulse.

The stimulus meets these assumptions because every input is driven once per cycle from one task, which returns the strobes to zero unless the next call raises them. The properties that involve collisions take the set pulse into account instead of forbidding it. The stimulus deliberately makes set pulses coincide with read-clears and write-clears.

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
  parameter int NSRC  = 20,
  parameter int CODEW = 5,
  parameter int VECW  = 8,
  parameter int NHI   = 4,
  parameter int HIW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_set,
  input  logic               mask_wr,
  input  logic [NSRC-1:0]    mask_wdata,
  output logic [NSRC-1:0]    mask_rd,
  input  logic               pend_lo_wr,
  input  logic [NSRC-NHI-1:0] pend_lo_wdata,
  output logic [NSRC-NHI-1:0] pend_lo,
  input  logic               pend_hi_wr,
  input  logic [HIW-1:0]     pend_hi_wdata,
  output logic [HIW-1:0]     pend_hi,
  input  logic               vec_rd,
  output logic [VECW-1:0]    vec,
  input  logic               irq_ack,
  output logic               irq
);
  localparam int NLO = NSRC - NHI;

  logic [NSRC-1:0]  pend_q, mask_q, act, wclr, rclr;
  logic [CODEW-1:0] code;
  logic             irq_q;

  assign act = pend_q & mask_q;

  always_comb begin
    code = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i]) code = CODEW'(i + 1);
  end

  always_comb begin
    rclr = '0;
    if (vec_rd && code != '0) rclr[code - CODEW'(1)] = 1'b1;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_map
    if (i < NHI) begin : g_hi
      assign wclr[i]          = pend_hi_wr & ~pend_hi_wdata[NHI-1-i];
      assign pend_hi[NHI-1-i] = pend_q[i];
    end else begin : g_lo
      assign wclr[i]      = pend_lo_wr & ~pend_lo_wdata[i-NHI];
      assign pend_lo[i-NHI] = pend_q[i];
    end
  end
  assign pend_hi[HIW-1:NHI] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~rclr & ~wclr) | src_set;
      if (mask_wr) mask_q <= mask_wdata;
      irq_q  <= (|act) & ~irq_ack;
    end
  end

  assign vec     = {{(VECW-CODEW){1'b0}}, code};
  assign mask_rd = mask_q;
  assign irq     = irq_q;
endmodule

module irq_vector_enc_chk #(
  parameter int NSRC  = 20,
  parameter int CODEW = 5,
  parameter int VECW  = 8,
  parameter int NHI   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      src_set,
  input logic [NSRC-1:0]      pend_q,
  input logic [NSRC-1:0]      mask_q,
  input logic                 pend_lo_wr,
  input logic [NSRC-NHI-1:0]  pend_lo_wdata,
  input logic [NSRC-NHI-1:0]  pend_lo,
  input logic                 vec_rd,
  input logic [VECW-1:0]      vec,
  input logic                 irq_ack,
  input logic                 irq
);
  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));

  p_none_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == '0) |-> (vec == '0));

  p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> (pend_q[vec[CODEW-1:0] - CODEW'(1)] && mask_q[vec[CODEW-1:0] - CODEW'(1)]));

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec != '0 && !src_set[vec[CODEW-1:0] - CODEW'(1)])
      |=> !pend_q[$past(vec[CODEW-1:0]) - CODEW'(1)]);

  p_write_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_lo_wr && (&pend_lo_wdata) && !vec_rd)
      |=> (pend_lo == ($past(pend_lo) | $past(src_set[NSRC-1:NHI]))));

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> (irq == $past(|(pend_q & mask_q))));

  p_ack_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec[VECW-1:CODEW] == '0);
endmodule

bind irq_vector_enc irq_vector_enc_chk #(.NSRC(NSRC), .CODEW(CODEW), .VECW(VECW), .NHI(NHI)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_set(src_set), .pend_q(pend_q), .mask_q(mask_q),
  .pend_lo_wr(pend_lo_wr), .pend_lo_wdata(pend_lo_wdata), .pend_lo(pend_lo),
  .vec_rd(vec_rd), .vec(vec), .irq_ack(irq_ack), .irq(irq)
);

// File: tb/irq_vector_enc_bench.sv
module irq_vector_enc_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [19:0] src_set = '0, mask_wdata = '0, mask_rd;
  logic        mask_wr = 1'b0, pend_lo_wr = 1'b0, pend_hi_wr = 1'b0;
  logic [15:0] pend_lo_wdata = '0, pend_lo;
  logic [7:0]  pend_hi_wdata = '0, pend_hi, vec;
  logic        vec_rd = 1'b0, irq_ack = 1'b0, irq;

  always #2 clk = ~clk;

  irq_vector_enc u_irq_vector_enc (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_rd(mask_rd), .pend_lo_wr(pend_lo_wr),
    .pend_lo_wdata(pend_lo_wdata), .pend_lo(pend_lo), .pend_hi_wr(pend_hi_wr),
    .pend_hi_wdata(pend_hi_wdata), .pend_hi(pend_hi), .vec_rd(vec_rd),
    .vec(vec), .irq_ack(irq_ack), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [19:0] m_pend = '0, m_mask = '0;
  logic        m_irq = 1'b0;
  logic [52:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [19:0] a);
    enc = '0;
    for (int i = 0; i < 20; i++) if (a[i]) enc = 5'(i + 1);
  endfunction

  task automatic drive(input string tag, input logic [19:0] set, input logic mwr, input logic [19:0] md,
                       input logic lwr, input logic [15:0] ld, input logic hwr, input logic [7:0] hd,
                       input logic rd, input logic ack);
    logic [19:0] act, clr, wc;
    logic [4:0]  c;
    logic [7:0]  hi;
    @(negedge clk);
    src_set = set; mask_wr = mwr; mask_wdata = md; pend_lo_wr = lwr; pend_lo_wdata = ld;
    pend_hi_wr = hwr; pend_hi_wdata = hd; vec_rd = rd; irq_ack = ack;
    act = m_pend & m_mask;
    c = enc(act);
    if (rd) check(tag, "returned vec", 32'(vec), 32'(c));
    clr = '0;
    if (rd && c != 0) clr[c - 5'd1] = 1'b1;
    wc = '0;
    for (int i = 0; i < 4; i++) if (hwr && !hd[3-i]) wc[i] = 1'b1;
    for (int i = 4; i < 20; i++) if (lwr && !ld[i-4]) wc[i] = 1'b1;
    m_irq  = (|act) && !ack;
    m_pend = (m_pend & ~clr & ~wc) | set;
    if (mwr) m_mask = md;
    hi = {4'b0, m_pend[0], m_pend[1], m_pend[2], m_pend[3]};
    exp_q.push_back({8'(enc(m_pend & m_mask)), m_pend[19:4], hi, m_mask, m_irq});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(tag, '0, 0, '0, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic rd(input string tag);
    drive(tag, '0, 0, '0, 0, '0, 0, '0, 1, 0);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [52:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "vec",     32'(vec),     32'(e[52:45]));
      check(t, "pend_lo", 32'(pend_lo), 32'(e[44:29]));
      check(t, "pend_hi", 32'(pend_hi), 32'(e[28:21]));
      check(t, "mask_rd", 32'(mask_rd), 32'(e[20:1]));
      check(t, "irq",     32'(irq),     32'(e[0]));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "reset vec", 32'(vec), 0);
    check("R3", "reset pend_lo", 32'(pend_lo), 0);
    check("R3", "reset pend_hi", 32'(pend_hi), 0);
    check("R3", "reset mask", 32'(mask_rd), 0);
    check("R3", "reset irq", 32'(irq), 0);

    drive("R1 R8 masked set", 20'h82011, 0, '0, 0, '0, 0, '0, 0, 0);
    idle("R8 masked irq stays low");
    drive("R8 mask load", '0, 1, 20'hFFFFF, 0, '0, 0, '0, 0, 0);
    idle("R9 irq rises");
    for (int k = 0; k < 5; k++) rd("R4 drain");
    rd("R11 read at zero");

    drive("R1 R6 set all", 20'hFFFFF, 0, '0, 0, '0, 0, '0, 0, 0);
    for (int k = 0; k < 21; k++) rd("R2 descending order");

    drive("R8 partial mask", 20'hF0F0F, 1, 20'h0A5A5, 0, '0, 0, '0, 0, 0);
    for (int k = 0; k < 6; k++) rd("R8 masked drain");
    drive("R8 unmask rest", '0, 1, 20'hFFFFF, 0, '0, 0, '0, 0, 0);
    rd("R2 after unmask");

    drive("R1 prep collide", 20'h00080, 0, '0, 0, '0, 0, '0, 0, 0);
    drive("R5 set vs read clear", 20'h00080, 0, '0, 0, '0, 0, '0, 1, 0);
    drive("R5 set vs write clear", 20'h00100, 0, '0, 1, 16'h0000, 0, '0, 0, 0);
    drive("R7 write ones", '0, 0, '0, 1, 16'hFFFF, 1, 8'hFF, 0, 0);
    drive("R7 clear some lo", '0, 0, '0, 1, 16'hFFEF, 0, '0, 0, 0);
    drive("R1 set hi", 20'h0000F, 0, '0, 0, '0, 0, '0, 0, 0);
    drive("R7 hi reserved ones", '0, 0, '0, 0, '0, 1, 8'hF5, 0, 0);
    drive("R10 ack", '0, 0, '0, 0, '0, 0, '0, 0, 1);
    idle("R10 irq returns");
    drive("R7 clear all", '0, 0, '0, 1, 16'h0000, 1, 8'hF0, 0, 0);
    idle("R9 irq falls");
    rd("R11 empty read");
    idle("R3 end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule